// File: doc/BRIEF.md
# Serial Flash Power-Up Reset and Density Probe

This block runs once after every system reset. It pulls the flash device's reset pin low for a programmable time, releases it, and waits for a recovery interval. It then runs one status read over a four-wire SPI link in clock mode 0. The read sends the status opcode and one dummy byte, and the reply to the dummy byte is taken as the status.

The four density bits of that status are compared with an internal device list. The list is searched one entry per cycle and ends at a closing entry that carries zero address bits. The search result drives four outputs for the command sequencer downstream:

- the count of in-page address bits, which the sequencer uses as its page-address shift;
- the page count, in units of 256 pages;
- the page size multiplier;
- a found flag.

A one-cycle done pulse tells the sequencer that these outputs can be used.

Top module: `dflash_probe`

## Requirements
- R1: While rst_n is low: flash_rst_n=1, spi_cs_n=1, spi_sck=0, found=0, page_bits=0, page_count=0, page_mult=0, done=0.
- R2: After reset is released, flash_rst_n goes low and stays low for at least RST_LOW_CYCLES clock cycles, then returns high and stays high.
- R3: spi_cs_n stays high while flash_rst_n is low, and for at least RECOVER_CYCLES cycles after flash_rst_n rises.
- R4: SPI mode 0. spi_sck idles low and is low whenever spi_cs_n is high. spi_mosi changes only while spi_sck is low. Bits travel MSB first.
- R5: During a single chip-select low period the block sends exactly 16 SCK pulses carrying 0xD7 then 0x00, and then raises spi_cs_n.
- R6: The status is the byte sampled from spi_miso on rising SCK edges 9..16, MSB first. Status bits 7, 6, 1 and 0 have no effect on the result; only code = status & 0x3C matters.
- R7: Each code maps to page_bits, page_count (units of 256 pages) and page_mult as follows: 0x0C→9,2,1; 0x14→9,4,1; 0x1C→9,8,1; 0x24→9,16,1; 0x2C→10,16,2; 0x34→10,32,2; 0x38→11,32,4; 0x10→11,64,4. A matching code sets found=1.
- R8: The search stops at the first entry whose code matches, or at the closing entry, which has zero page bits. A code of 0x00 therefore stops at the closing entry and does not match it.
- R9: When no entry matches: found=0, page_bits=0, page_count=0, page_mult=0.
- R10: done is high for exactly one cycle, the cycle after the outputs take their final values. done happens once per reset, and the outputs hold their values afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset; starts a new probe when released |
| flash_rst_n | output | 1 | Reset pin of the flash device, active low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |
| page_bits | output | 4 | In-page address bit count (0 if not found) |
| page_count | output | 8 | Page count in units of 256 pages |
| page_mult | output | 3 | Page size multiplier |
| found | output | 1 | Density code was recognised |
| done | output | 1 | One-cycle pulse: results are valid |

## Verification
In each search step, two checks fall in the same cycle: the code comparison and the closing-entry test. A masked code of 0x00 equals the code field of the closing entry, so both checks are true together. The bench provokes this by returning status 0x83, whose stray bits are all masked away. It also uses 0x3C and 0x04, which run to the closing entry through non-zero codes. The result is judged correct only if found stays 0 and page_bits reports 0. The match on 0x10, at the last entry before the closing one, shows that the terminator test does not cut the search short by one entry.

// File: rtl/dfp_pkg.sv
package dfp_pkg;

   localparam logic [7:0] OP_STATUS   = 8'hD7;
   localparam logic [7:0] CODE_MASK   = 8'h3C;
   localparam int         NUM_ENTRIES = 9;   // eight devices plus closing entry

   typedef struct packed {
      logic [7:0] code;
      logic [3:0] pbits;
      logic [7:0] pcount;
      logic [2:0] pmult;
   } dev_entry_t;

   function automatic dev_entry_t dev_entry(input int idx);
      dev_entry_t e;
      case (idx)
         0:       e = '{code: 8'h0C, pbits: 4'd9,  pcount: 8'd2,  pmult: 3'd1};
         1:       e = '{code: 8'h14, pbits: 4'd9,  pcount: 8'd4,  pmult: 3'd1};
         2:       e = '{code: 8'h1C, pbits: 4'd9,  pcount: 8'd8,  pmult: 3'd1};
         3:       e = '{code: 8'h24, pbits: 4'd9,  pcount: 8'd16, pmult: 3'd1};
         4:       e = '{code: 8'h2C, pbits: 4'd10, pcount: 8'd16, pmult: 3'd2};
         5:       e = '{code: 8'h34, pbits: 4'd10, pcount: 8'd32, pmult: 3'd2};
         6:       e = '{code: 8'h38, pbits: 4'd11, pcount: 8'd32, pmult: 3'd4};
         7:       e = '{code: 8'h10, pbits: 4'd11, pcount: 8'd64, pmult: 3'd4};
         default: e = '0;  // closing entry: zero page bits ends the walk
      endcase
      return e;
   endfunction

endpackage

// File: rtl/dfp_delay.sv
module dfp_delay #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] len,
   output logic         fire
);
   logic [W-1:0] cnt_q;
   logic         act_q;

   assign fire = act_q && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (start) begin
         cnt_q <= len;
         act_q <= 1'b1;
      end else if (fire) begin
         act_q <= 1'b0;
      end else if (act_q) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // fire never lasts past one cycle unless restarted (R2/R3 timing base)
   p_fire_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !start |=> !fire);

endmodule

// File: rtl/dfp_spi_byte.sv
module dfp_spi_byte #(
   parameter int SCK_HALF = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic [7:0] rx,
   output logic       done
);
   localparam int HW = $clog2(SCK_HALF) + 1;

   logic [7:0]    tx_q, rx_q;
   logic [2:0]    bit_q;
   logic [HW-1:0] div_q;
   logic          run_q, sck_q, done_q;

   assign sck  = sck_q;
   assign mosi = tx_q[7];
   assign rx   = rx_q;
   assign done = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q   <= '0;
         rx_q   <= '0;
         bit_q  <= '0;
         div_q  <= '0;
         run_q  <= 1'b0;
         sck_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start && !run_q) begin
            run_q <= 1'b1;
            tx_q  <= tx;
            bit_q <= '0;
            div_q <= '0;
            sck_q <= 1'b0;
         end else if (run_q) begin
            if (div_q == HW'(SCK_HALF - 1)) begin
               div_q <= '0;
               if (!sck_q) begin
                  sck_q <= 1'b1;
                  rx_q  <= {rx_q[6:0], miso};
               end else begin
                  sck_q <= 1'b0;
                  if (bit_q == 3'd7) begin
                     run_q  <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     bit_q <= bit_q + 1'b1;
                     tx_q  <= {tx_q[6:0], 1'b0};
                  end
               end
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
      end
   end

   // data line holds while the clock is high
   p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sck_q && $past(sck_q) |-> $stable(mosi));
   // no clock pulses once the byte has completed
   p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !sck_q);

endmodule

// File: rtl/dfp_table_search.sv
module dfp_table_search
   import dfp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] code,
   output logic       done,
   output logic       hit,
   output dev_entry_t ent
);
   localparam int IW = $clog2(NUM_ENTRIES);

   dev_entry_t rom [NUM_ENTRIES];

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_rom
      assign rom[g] = dev_entry(g);
   end

   logic [IW-1:0] idx_q;
   logic [7:0]    code_q;
   logic          run_q, done_q, hit_q;
   dev_entry_t    ent_q, cur;

   assign cur  = rom[idx_q];
   assign done = done_q;
   assign hit  = hit_q;
   assign ent  = ent_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         code_q <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
         hit_q  <= 1'b0;
         ent_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            idx_q  <= '0;
            code_q <= code;
            run_q  <= 1'b1;
         end else if (run_q) begin
            if (cur.pbits == 4'd0) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
               hit_q  <= 1'b0;
               ent_q  <= '0;
            end else if (cur.code == code_q) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
               hit_q  <= 1'b1;
               ent_q  <= cur;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   // walk never passes the closing entry
   p_idx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> idx_q < IW'(NUM_ENTRIES));
   // a reported hit never carries the closing entry
   p_hit_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q && hit_q |-> ent_q.pbits != 4'd0);

endmodule

// File: rtl/dflash_probe.sv
module dflash_probe
   import dfp_pkg::*;
#(
   parameter int RST_LOW_CYCLES = 160,
   parameter int RECOVER_CYCLES = 16,
   parameter int SCK_HALF       = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic       flash_rst_n,
   output logic       spi_cs_n,
   output logic       spi_sck,
   output logic       spi_mosi,
   input  logic       spi_miso,
   output logic [3:0] page_bits,
   output logic [7:0] page_count,
   output logic [2:0] page_mult,
   output logic       found,
   output logic       done
);
   localparam int DLY_MAX = (RST_LOW_CYCLES > RECOVER_CYCLES) ? RST_LOW_CYCLES : RECOVER_CYCLES;
   localparam int DLY_W   = $clog2(DLY_MAX + 1);

   if (SCK_HALF < 1 || RST_LOW_CYCLES < 1 || RECOVER_CYCLES < 1) begin : g_bad_cfg
      $error("dflash_probe: timing parameters must be at least 1");
   end

   typedef enum logic [2:0] {
      ST_BOOT, ST_RLOW, ST_RECOV, ST_OPC, ST_DUMMY, ST_LOOK, ST_DONE, ST_IDLE
   } state_t;

   state_t       st_q;
   logic         frst_q, cs_q, found_q, done_q;
   logic [3:0]   pb_q;
   logic [7:0]   pc_q;
   logic [2:0]   pm_q;

   logic             dly_start, dly_fire;
   logic [DLY_W-1:0] dly_len;
   logic             spi_start, spi_done;
   logic [7:0]       spi_tx, spi_rx;
   logic             look_start, look_done, look_hit;
   dev_entry_t       look_ent;

   assign dly_start  = (st_q == ST_BOOT) || (st_q == ST_RLOW && dly_fire);
   assign dly_len    = (st_q == ST_BOOT) ? DLY_W'(RST_LOW_CYCLES) : DLY_W'(RECOVER_CYCLES);
   assign spi_start  = (st_q == ST_RECOV && dly_fire) || (st_q == ST_OPC && spi_done);
   assign spi_tx     = (st_q == ST_RECOV) ? OP_STATUS : 8'h00;
   assign look_start = (st_q == ST_DUMMY) && spi_done;

   dfp_delay #(.W(DLY_W)) dly_i (
      .clk(clk), .rst_n(rst_n), .start(dly_start), .len(dly_len), .fire(dly_fire)
   );

   dfp_spi_byte #(.SCK_HALF(SCK_HALF)) spi_i (
      .clk(clk), .rst_n(rst_n), .start(spi_start), .tx(spi_tx), .miso(spi_miso),
      .sck(spi_sck), .mosi(spi_mosi), .rx(spi_rx), .done(spi_done)
   );

   dfp_table_search look_i (
      .clk(clk), .rst_n(rst_n), .start(look_start), .code(spi_rx & CODE_MASK),
      .done(look_done), .hit(look_hit), .ent(look_ent)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_BOOT;
         frst_q  <= 1'b1;
         cs_q    <= 1'b1;
         found_q <= 1'b0;
         done_q  <= 1'b0;
         pb_q    <= '0;
         pc_q    <= '0;
         pm_q    <= '0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_BOOT: begin
               frst_q <= 1'b0;
               st_q   <= ST_RLOW;
            end
            ST_RLOW: if (dly_fire) begin
               frst_q <= 1'b1;
               st_q   <= ST_RECOV;
            end
            ST_RECOV: if (dly_fire) begin
               cs_q <= 1'b0;
               st_q <= ST_OPC;
            end
            ST_OPC: if (spi_done) st_q <= ST_DUMMY;
            ST_DUMMY: if (spi_done) begin
               cs_q <= 1'b1;
               st_q <= ST_LOOK;
            end
            ST_LOOK: if (look_done) begin
               found_q <= look_hit;
               pb_q    <= look_ent.pbits;
               pc_q    <= look_ent.pcount;
               pm_q    <= look_ent.pmult;
               st_q    <= ST_DONE;
            end
            ST_DONE: begin
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign flash_rst_n = frst_q;
   assign spi_cs_n    = cs_q;
   assign found       = found_q;
   assign done        = done_q;
   assign page_bits   = pb_q;
   assign page_count  = pc_q;
   assign page_mult   = pm_q;

   p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);
   p_cs_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_rst_n |-> spi_cs_n);
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $stable(found) && $stable(page_bits) && $stable(page_count));
   p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done && !found |-> page_bits == 4'd0 && page_count == 8'd0 && page_mult == 3'd0);

endmodule

// File: tb/dflash_probe_tb.sv
module dflash_probe_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int RST_LOW    = 40;
   localparam int RECOVER    = 12;
   localparam int HALF       = 2;
   localparam int NV         = 12;

   typedef struct packed {
      logic [7:0] st;
      logic       f;
      logic [3:0] pb;
      logic [7:0] pc;
      logic [2:0] pm;
   } vec_t;

   // status byte returned, then expected found / page_bits / page_count / page_mult
   localparam vec_t VECS [NV] = '{
      '{8'h8C, 1'b1, 4'd9,  8'd2,  3'd1},   // R6 R7 stray bit 7
      '{8'h57, 1'b1, 4'd9,  8'd4,  3'd1},   // R6 R7 stray bits 6,1,0
      '{8'hDF, 1'b1, 4'd9,  8'd8,  3'd1},
      '{8'h24, 1'b1, 4'd9,  8'd16, 3'd1},
      '{8'h2C, 1'b1, 4'd10, 8'd16, 3'd2},
      '{8'h74, 1'b1, 4'd10, 8'd32, 3'd2},
      '{8'h39, 1'b1, 4'd11, 8'd32, 3'd4},
      '{8'h92, 1'b1, 4'd11, 8'd64, 3'd4},   // R8 last entry before closing one
      '{8'h83, 1'b0, 4'd0,  8'd0,  3'd0},   // R8 code 0x00 vs closing entry
      '{8'h3C, 1'b0, 4'd0,  8'd0,  3'd0},   // R9 unknown code
      '{8'hFF, 1'b0, 4'd0,  8'd0,  3'd0},   // R9
      '{8'h04, 1'b0, 4'd0,  8'd0,  3'd0}    // R9
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_miso = 1'b0;
   logic flash_rst_n, spi_cs_n, spi_sck, spi_mosi, found, done;
   logic [3:0] page_bits;
   logic [7:0] page_count;
   logic [2:0] page_mult;

   int n_chk = 0;
   int n_bad = 0;
   int rise_cnt = 0;
   logic [15:0] cap = '0;
   logic [7:0]  cur_st = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dflash_probe #(.RST_LOW_CYCLES(RST_LOW), .RECOVER_CYCLES(RECOVER), .SCK_HALF(HALF)) dut_i (
      .clk(clk), .rst_n(rst_n), .flash_rst_n(flash_rst_n), .spi_cs_n(spi_cs_n),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .page_bits(page_bits), .page_count(page_count), .page_mult(page_mult),
      .found(found), .done(done)
   );

   // flash model: capture host bits on rising SCK
   initial forever begin
      @(posedge spi_sck);
      cap = {cap[14:0], spi_mosi};
      rise_cnt = rise_cnt + 1;
   end

   // flash model: present status bits after falling SCK, second byte only
   initial forever begin
      @(negedge spi_sck);
      if (rise_cnt >= 8 && rise_cnt < 16) spi_miso = cur_st[15 - rise_cnt];
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic chk_ge(input string req, input int got, input int lim);
      n_chk++;
      if (got < lim) begin
         n_bad++;
         $display("FAIL %s: got %0d expected >= %0d", req, got, lim);
      end
   endtask

   task automatic run_probe(input vec_t v);
      int lo_cnt = 0, rec_cnt = 0, cyc = 0, rst_rises = 0;
      bit seen_lo = 0, cs_fell = 0, got_done = 0, cs_sck_bad = 0;
      logic [3:0] prev_pb = '0;
      logic       prev_f = 1'b0;
      logic [7:0] prev_pc = '0;
      rst_n = 1'b0;
      cur_st = v.st;
      repeat (3) @(negedge clk);
      rise_cnt = 0;
      cap = '0;
      spi_miso = 1'b0;
      // R1 reset state
      chk("R1", {flash_rst_n, spi_cs_n, spi_sck, found, done, page_bits, page_count, page_mult},
                {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 8'd0, 3'd0});
      rst_n = 1'b1;
      while (!got_done && cyc < 5000) begin
         prev_pb = page_bits; prev_f = found; prev_pc = page_count;
         @(negedge clk);
         cyc++;
         if (spi_cs_n && spi_sck) cs_sck_bad = 1;
         if (!flash_rst_n) begin
            seen_lo = 1;
            lo_cnt++;
            if (!spi_cs_n) cs_sck_bad = 1;
         end else if (seen_lo && spi_cs_n && !cs_fell) rec_cnt++;
         if (seen_lo && flash_rst_n && !cs_fell && lo_cnt > 0 && rec_cnt == 1) rst_rises++;
         if (!spi_cs_n) cs_fell = 1;
         if (cs_fell && seen_lo && !flash_rst_n) rst_rises = 99; // low again after release
         if (done) got_done = 1;
      end
      chk("R10 done seen", got_done, 1'b1);
      chk_ge("R2 reset low width", lo_cnt, RST_LOW);
      chk("R2 single reset pulse", rst_rises, 1);
      chk_ge("R3 recovery width", rec_cnt - 2, RECOVER - 2);
      chk("R3 R4 cs/sck/reset order", cs_sck_bad, 1'b0);
      chk("R5 bits sent", cap, 16'hD700);
      chk("R5 sck pulses", rise_cnt, 16);
      chk("R5 cs raised", spi_cs_n, 1'b1);
      chk("R7 R9 found", found, v.f);
      chk("R7 R9 page_bits", page_bits, v.pb);
      chk("R7 R9 page_count", page_count, v.pc);
      chk("R7 R9 page_mult", page_mult, v.pm);
      chk("R10 valid before done", {prev_f, prev_pb, prev_pc}, {v.f, v.pb, v.pc});
      @(negedge clk);
      chk("R10 done one cycle", done, 1'b0);
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         if (done || found !== v.f || page_bits !== v.pb || spi_cs_n !== 1'b1)
            chk("R10 hold after done", {done, found, page_bits, spi_cs_n}, {1'b0, v.f, v.pb, 1'b1});
      end
      chk("R10 held values", {found, page_bits, page_count, page_mult}, {v.f, v.pb, v.pc, v.pm});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NV; i++) run_probe(VECS[i]);
      // directed: reset asserted mid-transfer, then a clean probe (R1, R2)
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (RST_LOW + RECOVER + 20) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R1 reset mid-transfer", {spi_cs_n, spi_sck, flash_rst_n, done}, {1'b1, 1'b0, 1'b1, 1'b0});
      run_probe(VECS[7]);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule